// File: doc/BRIEF.md
# Folded Bit-Serial Distributed-Arithmetic FIR

This block is one FIR sub-filter that has no multipliers. Each product sum comes from small constant tables. The tables are built at elaboration from the coefficient parameter. The rows of the tap delay line feed the tables one bit-plane at a time. A shift-weighted accumulator then combines the table outputs into the full-precision result.

The folding factor `FOLD` sets how many clocks one output takes. Each clock handles `DATA_W/FOLD` bit-planes. With `FOLD = DATA_W` one table bank serves the whole word, which gives the smallest area. With `FOLD = 1` every bit-plane has its own bank, and one result comes out per clock.

The host presents a parallel sample with `in_valid_i`. After `FOLD` clocks the result appears with a one-cycle `out_valid_o` pulse. A sample offered while the filter is still working is dropped, and `overrun_o` reports the drop.

Top module: `da_fir_folded`

## Requirements
- R1: While `rst_ni` is low and after its release, `out_valid_o` and `overrun_o` are 0 and `out_data_o` is all zero. The tap delay line holds zeros.
- R2: A result equals the sum over k of `COEFS[k] * x[n-k]`. Here x[n] is the newest accepted sample, samples are two's complement `DATA_W`-bit values, and taps older than the first accepted sample count as zero. The result is a signed `OUT_W`-bit value that is never truncated.
- R3: A sample accepted at clock edge E produces `out_valid_o` high for exactly one cycle, starting at edge E+FOLD. `out_valid_o` is never high at any other time.
- R4: A sample presented in the final cycle of a computation is accepted, so samples held back-to-back are taken every `FOLD` clocks. With `FOLD = 1` a sample is taken on every clock.
- R5: A sample presented while a computation is in progress, other than in its final cycle, is dropped. It does not enter the delay line and does not change any later result. `overrun_o` is high for exactly the cycle after each dropped sample and is low otherwise.
- R6: The most negative sample (-2^(DATA_W-1)) and the most negative coefficient give exact signed products, because the sign bit-plane is weighted negatively.
- R7: `out_data_o` changes only at the edge that raises `out_valid_o`, and holds its value between result pulses.
- R8: While `in_valid_i` stays low, no result pulse and no overrun occur once pending work has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Filter clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_valid_i | input | 1 | Sample strobe |
| in_data_i | input | DATA_W | Two's-complement input sample |
| out_valid_o | output | 1 | One-cycle result strobe |
| out_data_o | output | OUT_W | Full-precision filter result |
| overrun_o | output | 1 | Pulses the cycle after a sample is dropped |

## Verification
The bench drives a fully serial instance (FOLD 12) and a fully parallel one (FOLD 1) with identical stimulus:
- an impulse train,
- a constant valid stream,
- sparse random strobes,
- full-scale alternating extremes.

A wrong final-cycle acceptance rule either loses a slot, which stretches the result spacing to FOLD+1, or shifts the delay line mid-computation, which corrupts the current result. Adding the sign bit-plane instead of subtracting it gives wrong results for negative samples. The extreme-value phase exposes this, as well as any product width that is too narrow.

A dropped sample that leaked into the delay line would show up as a wrong value in a later result. A missing or stretched overrun pulse is caught cycle by cycle against the reference model.

// File: rtl/da_fir_pkg.sv
`timescale 1ns/1ps
package da_fir_pkg;
  localparam int LUT_IN    = 4;
  localparam int LUT_DEPTH = 1 << LUT_IN;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/da_tap_line.sv
`timescale 1ns/1ps
module da_tap_line #(
  parameter int DATA_W   = 12,
  parameter int NUM_TAPS = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         shift_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [NUM_TAPS*DATA_W-1:0]   taps_o
);
  logic [DATA_W-1:0] tap_q [NUM_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_TAPS; k++) tap_q[k] <= '0;
    end else if (shift_i) begin
      tap_q[0] <= data_i;
      for (int k = 1; k < NUM_TAPS; k++) tap_q[k] <= tap_q[k-1];
    end
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_flat
    assign taps_o[k*DATA_W +: DATA_W] = tap_q[k];
  end
endmodule

// File: rtl/da_plane.sv
`timescale 1ns/1ps
// One bit-plane: 4-input partial tables summed across tap groups.
module da_plane
  import da_fir_pkg::*;
#(
  parameter int NUM_TAPS = 8,
  parameter int COEF_W   = 10,
  parameter int SUM_W    = 13,
  parameter logic signed [COEF_W-1:0] COEFS [NUM_TAPS] = '{default: '0}
) (
  input  logic [NUM_TAPS-1:0]      bits_i,
  output logic signed [SUM_W-1:0]  sum_o
);
  localparam int NUM_GRP = ceil_div(NUM_TAPS, LUT_IN);
  localparam int PAD_W   = NUM_GRP * LUT_IN;

  function automatic logic signed [SUM_W-1:0] lut_entry(input int g, input int a);
    logic signed [SUM_W-1:0] s;
    s = '0;
    for (int k = 0; k < LUT_IN; k++) begin
      if ((((a >> k) & 1) == 1) && ((g*LUT_IN + k) < NUM_TAPS))
        s = s + SUM_W'(COEFS[g*LUT_IN + k]);
    end
    return s;
  endfunction

  logic [PAD_W-1:0]        pad;
  logic signed [SUM_W-1:0] grp [NUM_GRP];

  assign pad = PAD_W'(bits_i);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic signed [SUM_W-1:0] lut [LUT_DEPTH];
    for (genvar e = 0; e < LUT_DEPTH; e++) begin : g_ent
      assign lut[e] = lut_entry(g, e);
    end
    assign grp[g] = lut[pad[g*LUT_IN +: LUT_IN]];
  end

  always_comb begin
    sum_o = '0;
    for (int g = 0; g < NUM_GRP; g++) sum_o = sum_o + grp[g];
  end
endmodule

// File: rtl/da_fir_folded.sv
`timescale 1ns/1ps
module da_fir_folded #(
  parameter int DATA_W   = 12,
  parameter int NUM_TAPS = 8,
  parameter int COEF_W   = 10,
  parameter int FOLD     = 12,
  parameter logic signed [COEF_W-1:0] COEFS [NUM_TAPS] =
    '{-10'sd5, 10'sd12, -10'sd40, 10'sd150, 10'sd200, -10'sd60, 10'sd25, -10'sd9},
  localparam int OUT_W   = DATA_W + COEF_W + $clog2(NUM_TAPS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  output logic              out_valid_o,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              overrun_o
);
  localparam int BPC   = DATA_W / FOLD;
  localparam int CNT_W = (FOLD > 1) ? $clog2(FOLD) : 1;
  localparam int SUM_W = COEF_W + $clog2(NUM_TAPS);

  if ((DATA_W % FOLD) != 0) begin : g_bad_fold
    $error("FOLD must divide DATA_W");
  end

  logic                         busy_q;
  logic [CNT_W-1:0]             cnt_q;
  logic signed [OUT_W-1:0]      acc_q, step, out_q;
  logic                         out_vld_q, ovr_q;
  logic                         last, accept;
  logic [NUM_TAPS*DATA_W-1:0]   taps;
  logic [NUM_TAPS-1:0]          plane_bits [BPC];
  logic signed [SUM_W-1:0]      plane_sum  [BPC];

  // final compute cycle frees the slot for the next sample (R4)
  assign last   = busy_q && (int'(cnt_q) == FOLD - 1);
  assign accept = in_valid_i && (!busy_q || last);

  da_tap_line #(.DATA_W(DATA_W), .NUM_TAPS(NUM_TAPS)) u_taps (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .shift_i (accept),
    .data_i  (in_data_i),
    .taps_o  (taps)
  );

  always_comb begin
    for (int j = 0; j < BPC; j++) begin
      for (int k = 0; k < NUM_TAPS; k++) begin
        plane_bits[j][k] = taps[k*DATA_W + int'(cnt_q)*BPC + j];
      end
    end
  end

  for (genvar j = 0; j < BPC; j++) begin : g_plane
    da_plane #(
      .NUM_TAPS (NUM_TAPS),
      .COEF_W   (COEF_W),
      .SUM_W    (SUM_W),
      .COEFS    (COEFS)
    ) u_plane (
      .bits_i (plane_bits[j]),
      .sum_o  (plane_sum[j])
    );
  end

  // weight each plane by its bit position; sign plane is negative (R6)
  always_comb begin
    step = '0;
    for (int j = 0; j < BPC; j++) begin
      int b;
      logic signed [OUT_W-1:0] term;
      b    = int'(cnt_q)*BPC + j;
      term = OUT_W'(plane_sum[j]) <<< b;
      if (b == DATA_W - 1) step = step - term;
      else                 step = step + term;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      acc_q     <= '0;
      out_q     <= '0;
      out_vld_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      out_vld_q <= last;
      ovr_q     <= in_valid_i && !accept;
      if (last) out_q <= acc_q + step;
      if (accept) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
        acc_q  <= '0;
      end else if (last) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q  <= cnt_q + 1'b1;
        acc_q  <= acc_q + step;
      end
    end
  end

  assign out_valid_o = out_vld_q;
  assign out_data_o  = out_q;
  assign overrun_o   = ovr_q;
endmodule

// File: rtl/da_fir_folded_chk.sv
`timescale 1ns/1ps
module da_fir_folded_chk #(
  parameter int FOLD  = 12,
  parameter int OUT_W = 25
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             out_valid_o,
  input logic [OUT_W-1:0] out_data_o,
  input logic             overrun_o
);
  localparam int RW = $clog2(FOLD + 1);

  // cycles left until the pending result is due
  logic [RW-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rem_q <= '0;
    else if (in_valid_i && rem_q <= 1)  rem_q <= RW'(FOLD);
    else if (rem_q != 0)                rem_q <= rem_q - 1'b1;
  end

  a_r3_result_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q == 1) |=> out_valid_o);

  a_r3_no_stray_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_q != 1) |=> !out_valid_o);

  a_r5_drop_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && rem_q > 1) |=> overrun_o);

  a_r5_no_false_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && rem_q > 1) |=> !overrun_o);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> $stable(out_data_o));
endmodule

bind da_fir_folded da_fir_folded_chk #(.FOLD(FOLD), .OUT_W(OUT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o),
  .overrun_o   (overrun_o)
);

// File: tb/da_fir_folded_tb_top.sv
`timescale 1ns/1ps
module da_fir_folded_tb_top;
  localparam int DW = 12;
  localparam int NT = 8;
  localparam int CW = 10;
  localparam int OW = DW + CW + 3;
  localparam logic signed [CW-1:0] TB_COEFS [NT] =
    '{-10'sd5, 10'sd12, -10'sd40, 10'sd150, 10'sd200, -10'sd60, 10'sd25, -10'sd512};
  int coef_m [NT] = '{-5, 12, -40, 150, 200, -60, 25, -512};
  int fold_m [2]  = '{12, 1};

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic ov0, ovr0, ov1, ovr1;
  logic [OW-1:0] od0, od1;

  always #5 clk_i = ~clk_i;

  da_fir_folded #(.DATA_W(DW), .NUM_TAPS(NT), .COEF_W(CW), .FOLD(12), .COEFS(TB_COEFS)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(ov0), .out_data_o(od0), .overrun_o(ovr0));

  da_fir_folded #(.DATA_W(DW), .NUM_TAPS(NT), .COEF_W(CW), .FOLD(1), .COEFS(TB_COEFS)) dut_r1_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_data_i(in_data),
    .out_valid_o(ov1), .out_data_o(od1), .overrun_o(ovr1));

  int n_checks = 0;
  int n_fail   = 0;
  string tag_v = "R3";
  string tag_d = "R2";

  // behavioural reference model
  int m_taps [2][NT];
  bit m_busy [2];
  int m_cnt  [2];
  bit m_ov   [2];
  bit m_ovr  [2];
  int m_out  [2];
  int m_pend [2];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2; i++) begin
        for (int k = 0; k < NT; k++) m_taps[i][k] = 0;
        m_busy[i] = 0; m_cnt[i] = 0; m_ov[i] = 0; m_ovr[i] = 0;
        m_out[i] = 0; m_pend[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        bit lst, acc;
        lst = m_busy[i] && (m_cnt[i] == fold_m[i] - 1);
        acc = in_valid && (!m_busy[i] || lst);
        m_ov[i]  = lst;
        m_ovr[i] = in_valid && !acc;
        if (lst) m_out[i] = m_pend[i];
        if (acc) begin
          for (int k = NT - 1; k > 0; k--) m_taps[i][k] = m_taps[i][k-1];
          m_taps[i][0] = int'($signed(in_data));
          m_pend[i] = 0;
          for (int k = 0; k < NT; k++) m_pend[i] += m_taps[i][k] * coef_m[k];
          m_busy[i] = 1; m_cnt[i] = 0;
        end else if (lst) begin
          m_busy[i] = 0;
        end else if (m_busy[i]) begin
          m_cnt[i]++;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk(tag_v, "fold12 out_valid", int'(ov0), int'(m_ov[0]));
    chk(tag_v, "fold1 out_valid",  int'(ov1), int'(m_ov[1]));
    chk("R5", "fold12 overrun", int'(ovr0), int'(m_ovr[0]));
    chk("R5", "fold1 overrun",  int'(ovr1), int'(m_ovr[1]));
    chk(m_ov[0] ? tag_d : "R7", "fold12 out_data", int'($signed(od0)), m_out[0]);
    chk(m_ov[1] ? tag_d : "R7", "fold1 out_data",  int'($signed(od1)), m_out[1]);
  endtask

  task automatic drive(input bit v, input int d);
    @(negedge clk_i);
    check_all();
    in_valid = v;
    in_data  = DW'(d);
  endtask

  int unsigned lcg = 32'h1234_5678;
  function automatic int unsigned nxt();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg >> 8;
  endfunction

  bit done = 0;
  int cyc  = 0;
  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog expired actual %0d expected below 100000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk_i);
    chk("R1", "fold12 out_valid in reset", int'(ov0), 0);
    chk("R1", "fold12 overrun in reset",   int'(ovr0), 0);
    chk("R1", "fold12 out_data in reset",  int'(od0), 0);
    chk("R1", "fold1 out_data in reset",   int'(od1), 0);
    rst_ni = 1'b1;
    drive(0, 0);
    drive(0, 0);
    chk("R1", "fold12 data after release", int'(od0), 0);

    // R2 / R3: impulse response, spaced samples
    tag_v = "R3"; tag_d = "R2";
    drive(1, 1);
    repeat (13) drive(0, 0);
    for (int s = 0; s < 9; s++) begin
      drive(1, 0);
      repeat (12) drive(0, 0);
    end

    // R4: constant strobe, back-to-back acceptance
    tag_v = "R4";
    for (int s = 0; s < 200; s++) drive(1, int'(nxt() & 12'hfff));

    // R5: sparse random strobes
    tag_v = "R3";
    for (int s = 0; s < 300; s++) drive((nxt() % 3) == 0, int'(nxt() & 12'hfff));

    // R6: full-scale extremes
    tag_d = "R6";
    for (int s = 0; s < 40; s++) begin
      drive(1, (s % 3 == 2) ? 2047 : -2048);
      repeat (11) drive(0, 0);
    end
    repeat (14) drive(0, 0);

    // R8: idle, nothing may happen
    tag_v = "R8"; tag_d = "R2";
    repeat (50) drive(0, 0);
    chk("R8", "fold12 idle overrun", int'(ovr0), 0);
    chk("R8", "fold1 idle out_valid", int'(ov1), 0);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule